// File: doc/BRIEF.md
# Multi-Context Lookup-Table Logic Cell

This block is one reconfigurable logic element. Its function is a truth table indexed by its input vector, and it stores several complete truth tables side by side as separate contexts. Exactly one context drives the lookup at any moment. A selection strobe picks the active context: on the rising edge of the strobe, the cell samples a small context index. The registered cell output can replace any lookup input bit, so the cell can consume its own output from the previous cycle. With that feedback a single cell forms a flip-flop or a toggle.

A single-bit, memory-style access port addresses every stored configuration bit, in the active context and in the inactive ones. The lookup logic sees the whole active table in parallel while the port reads or writes one bit, so the store behaves as dual-ported. The same port has one extra location mapped onto the registered output. A host or the surrounding fabric can use it to probe the cell's state, or to preset it before a circuit starts, for example when saving and restoring a context.

Top module: `mctx_lut_cell`

## Requirements
- R1: When a clock edge sees `rst_n` low, the output is cleared, context 0 becomes active and every stored configuration bit is cleared. After reset, every port read therefore returns 0.
- R2: At each clock edge without a state write, `cell_o` takes the bit of the active context's truth table whose position equals the lookup index. Lookup input bit i is bit i of that index.
- R3: Port address layout: the MSB set to 0 selects the table space, with the context in bits [5:4] and the truth-table bit in bits [3:0]. A write with `cfg_we_i` high stores `cfg_wdata_i` at the clock edge. `cfg_rdata_o` shows the addressed bit combinationally.
- R4: A write to an inactive context does not change `cell_o`, and the new bit reads back through the port.
- R5: A rising edge of `ctx_trig_i` (high now, low in the previous cycle) makes `ctx_idx_i` the active context at that clock edge. The lookup in that same edge still uses the old context, and the new one applies from the next edge.
- R6: While `ctx_trig_i` is held high or is falling, changes on `ctx_idx_i` do not change the active context.
- R7: If a port write changes the active context's bit that is being looked up in the same cycle, `cell_o` shows the old bit at that edge and the new bit from the next edge.
- R8: When bit i of `fb_sel_i` is high, lookup input i is the registered `cell_o` from the previous cycle instead of `data_i[i]`. With a table that inverts input 0, the output therefore toggles every cycle.
- R9: Address MSB set to 1 selects the state location. A read there returns `cell_o`. A write there loads `cfg_wdata_i` into the output and overrides the lookup at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_i | input | NUM_IN | Lookup inputs from the fabric |
| fb_sel_i | input | NUM_IN | Per input: use previous output instead of data |
| ctx_trig_i | input | 1 | Context selection strobe, acts on rising edge |
| ctx_idx_i | input | CTX_W | Context index sampled on strobe edge |
| cfg_we_i | input | 1 | Port write enable |
| cfg_addr_i | input | NUM_IN+CTX_W+1 | Port address (table bit or state) |
| cfg_wdata_i | input | 1 | Port write data |
| cfg_rdata_o | output | 1 | Port read data, combinational |
| cell_o | output | 1 | Registered cell output |

## Verification
The assertions rely on the strobe, index and port signals being driven synchronously and held stable across each edge. The stimulus therefore changes every input only on the falling clock edge. The checks also rely on the single port making at most one access per cycle, so a table write and a state write never coincide. The bench keeps `rst_n` low for several edges before the first release, so the strobe history seen by the edge detector and by the properties agrees from the start.

// File: rtl/mctx_pkg.sv
// Shared definitions for the multi-context lookup cell.
// Assumes: the port address MSB splits table space from state space.
package mctx_pkg;

    // Which space a port address refers to.
    typedef enum logic {
        SPACE_TABLE = 1'b0,
        SPACE_STATE = 1'b1
    } cfg_space_e;

    // Truth-table size for a given number of lookup inputs.
    function automatic int unsigned tbl_bits(input int unsigned n_in);
        return 32'd1 << n_in;
    endfunction

endpackage

// File: rtl/mctx_ctx_store.sv
// Configuration store holding NUM_CTX truth tables.
// The whole active table is presented in parallel to the lookup logic.
// One bit is read or written through an independent address-selected path.
// Assumes: the write and read selectors are already decoded by the parent.
module mctx_ctx_store #(
    parameter int unsigned NUM_IN  = 4,
    parameter int unsigned NUM_CTX = 4,
    localparam int unsigned TBL    = mctx_pkg::tbl_bits(NUM_IN),
    localparam int unsigned CTX_W  = $clog2(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTX_W-1:0] wr_ctx,
    input  logic [NUM_IN-1:0] wr_bit,
    input  logic             wr_data,
    input  logic [CTX_W-1:0] act_ctx,
    input  logic [CTX_W-1:0] rd_ctx,
    input  logic [NUM_IN-1:0] rd_bit,
    output logic [TBL-1:0]   act_table,
    output logic             rd_data
);

    logic [NUM_CTX-1:0][TBL-1:0] mem;

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        // One context row: cleared on reset, single-bit writes from the port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (wr_en && (wr_ctx == CTX_W'(g))) begin
                mem[g][wr_bit] <= wr_data;
            end
        end
    end

    // Parallel read of the active table for the lookup.
    always_comb act_table = mem[act_ctx];

    // Single-bit read for the access port.
    always_comb rd_data = mem[rd_ctx][rd_bit];

endmodule

// File: rtl/mctx_trig_sel.sv
// Active-context register driven by a rising-edge selection strobe.
// Assumes: strobe and index are synchronous to clk. The strobe history is
// sampled during reset too, so a strobe held high through reset is no edge.
module mctx_trig_sel #(
    parameter int unsigned NUM_CTX = 4,
    localparam int unsigned CTX_W  = $clog2(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic [CTX_W-1:0] idx_i,
    output logic [CTX_W-1:0] act_ctx_o
);

    logic trig_q;
    logic trig_rise;

    // Previous strobe level, tracked in all cycles.
    always_ff @(posedge clk) trig_q <= trig_i;

    // Rising edge relative to the previous cycle.
    always_comb trig_rise = trig_i & ~trig_q;

    // Load the sampled index on an edge, context 0 after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_ctx_o <= '0;
        end else if (trig_rise) begin
            act_ctx_o <= idx_i;
        end
    end

endmodule

// File: rtl/mctx_lut_core.sv
// Lookup with per-input feedback selection and a registered output.
// Assumes: the table is the active context, and a state write has priority.
module mctx_lut_core #(
    parameter int unsigned NUM_IN = 4,
    localparam int unsigned TBL   = mctx_pkg::tbl_bits(NUM_IN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] data_i,
    input  logic [NUM_IN-1:0] fb_sel_i,
    input  logic [TBL-1:0]    table_i,
    input  logic              st_we,
    input  logic              st_wdata,
    output logic              out_o
);

    logic [NUM_IN-1:0] lut_idx;
    logic              lut_bit;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_in
        // Input g: fabric data or the previous-cycle output.
        always_comb lut_idx[g] = fb_sel_i[g] ? out_o : data_i[g];
    end

    // Truth-table lookup.
    always_comb lut_bit = table_i[lut_idx];

    // Output register: reset, state preset, then the normal lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_o <= 1'b0;
        end else if (st_we) begin
            out_o <= st_wdata;
        end else begin
            out_o <= lut_bit;
        end
    end

endmodule

// File: rtl/mctx_lut_cell.sv
// Top of the multi-context lookup cell.
// Decodes the access port into table and state spaces and connects the store,
// the context selector and the lookup core.
// Assumes: one port access per cycle, and NUM_CTX is a power of two >= 2.
module mctx_lut_cell #(
    parameter int unsigned NUM_IN  = 4,
    parameter int unsigned NUM_CTX = 4,
    localparam int unsigned TBL    = mctx_pkg::tbl_bits(NUM_IN),
    localparam int unsigned CTX_W  = $clog2(NUM_CTX),
    localparam int unsigned AW     = NUM_IN + CTX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] data_i,
    input  logic [NUM_IN-1:0] fb_sel_i,
    input  logic              ctx_trig_i,
    input  logic [CTX_W-1:0]  ctx_idx_i,
    input  logic              cfg_we_i,
    input  logic [AW-1:0]     cfg_addr_i,
    input  logic              cfg_wdata_i,
    output logic              cfg_rdata_o,
    output logic              cell_o
);

    import mctx_pkg::*;

    cfg_space_e        space;
    logic [CTX_W-1:0]  addr_ctx;
    logic [NUM_IN-1:0] addr_bit;
    logic              tbl_we;
    logic              st_we;
    logic [CTX_W-1:0]  act_ctx;
    logic [TBL-1:0]    act_table;
    logic              tbl_rd;

    // Split the port address into its fields.
    always_comb begin
        space    = cfg_space_e'(cfg_addr_i[AW-1]);
        addr_ctx = cfg_addr_i[NUM_IN +: CTX_W];
        addr_bit = cfg_addr_i[NUM_IN-1:0];
    end

    // Steer the write enable to the addressed space.
    always_comb begin
        tbl_we = cfg_we_i && (space == SPACE_TABLE);
        st_we  = cfg_we_i && (space == SPACE_STATE);
    end

    mctx_ctx_store #(.NUM_IN(NUM_IN), .NUM_CTX(NUM_CTX)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_we),
        .wr_ctx    (addr_ctx),
        .wr_bit    (addr_bit),
        .wr_data   (cfg_wdata_i),
        .act_ctx   (act_ctx),
        .rd_ctx    (addr_ctx),
        .rd_bit    (addr_bit),
        .act_table (act_table),
        .rd_data   (tbl_rd)
    );

    mctx_trig_sel #(.NUM_CTX(NUM_CTX)) sel_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (ctx_trig_i),
        .idx_i     (ctx_idx_i),
        .act_ctx_o (act_ctx)
    );

    mctx_lut_core #(.NUM_IN(NUM_IN)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_i   (data_i),
        .fb_sel_i (fb_sel_i),
        .table_i  (act_table),
        .st_we    (st_we),
        .st_wdata (cfg_wdata_i),
        .out_o    (cell_o)
    );

    // Read mux: state location or stored table bit.
    always_comb cfg_rdata_o = (space == SPACE_STATE) ? cell_o : tbl_rd;

endmodule

// File: rtl/mctx_lut_cell_chk.sv
// Checker for mctx_lut_cell, attached with bind.
// Assumes: inputs are synchronous and there is one port access per cycle.
module mctx_lut_cell_chk #(
    parameter int unsigned NUM_IN  = 4,
    parameter int unsigned NUM_CTX = 4,
    localparam int unsigned CTX_W  = $clog2(NUM_CTX),
    localparam int unsigned AW     = NUM_IN + CTX_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctx_trig_i,
    input logic [CTX_W-1:0] ctx_idx_i,
    input logic             cfg_we_i,
    input logic [AW-1:0]    cfg_addr_i,
    input logic             cfg_wdata_i,
    input logic             cfg_rdata_o,
    input logic             cell_o,
    input logic [CTX_W-1:0] act_ctx
);

    // R1: the first cycle after reset shows a cleared output and context 0.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cell_o == 1'b0 && act_ctx == '0));

    // R3: a table write reads back in the next cycle at the same address.
    a_r3_table_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && !cfg_addr_i[AW-1]) |=>
        ((cfg_addr_i != $past(cfg_addr_i)) || (cfg_rdata_o == $past(cfg_wdata_i))));

    // R5: a strobe rising edge loads the index as the active context.
    a_r5_edge_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_trig_i && !$past(ctx_trig_i)) |=> (act_ctx == $past(ctx_idx_i)));

    // R6: without a rising edge the active context holds.
    a_r6_ctx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctx_trig_i && !$past(ctx_trig_i)) |=> $stable(act_ctx));

    // R9: a state write sets the output at the next edge.
    a_r9_state_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_addr_i[AW-1]) |=> (cell_o == $past(cfg_wdata_i)));

endmodule

bind mctx_lut_cell mctx_lut_cell_chk #(.NUM_IN(NUM_IN), .NUM_CTX(NUM_CTX)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctx_trig_i  (ctx_trig_i),
    .ctx_idx_i   (ctx_idx_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .cell_o      (cell_o),
    .act_ctx     (act_ctx)
);

// File: tb/mctx_lut_cell_tb_top.sv
// Self-checking bench for mctx_lut_cell: sweeps every table bit and every
// input pattern in each context and compares against an arithmetic model.
module mctx_lut_cell_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] data_i = '0;
    logic [3:0] fb_sel_i = '0;
    logic       ctx_trig_i = 1'b0;
    logic [1:0] ctx_idx_i = '0;
    logic       cfg_we_i = 1'b0;
    logic [6:0] cfg_addr_i = '0;
    logic       cfg_wdata_i = 1'b0;
    logic       cfg_rdata_o;
    logic       cell_o;

    int checks = 0;
    int fails  = 0;
    logic tbl [4][16];
    int act = 0;

    always #2 clk = ~clk;

    mctx_lut_cell dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_i      (data_i),
        .fb_sel_i    (fb_sel_i),
        .ctx_trig_i  (ctx_trig_i),
        .ctx_idx_i   (ctx_idx_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .cfg_rdata_o (cfg_rdata_o),
        .cell_o      (cell_o)
    );

    function automatic logic fgen(input int c, input int i);
        return logic'(((i * (2 * c + 3) + c) >> 1) & 1);
    endfunction

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_wr(input int a, input logic d);
        cfg_we_i = 1'b1;
        cfg_addr_i = 7'(a);
        cfg_wdata_i = d;
        tick();
        cfg_we_i = 1'b0;
    endtask

    task automatic select_ctx(input int c);
        ctx_idx_i = 2'(c);
        ctx_trig_i = 1'b1;
        tick();
        ctx_trig_i = 1'b0;
        act = c;
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 16; i++) begin
            data_i = 4'(i);
            tick();
            chk(tag, cell_o, tbl[act][i]);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int i0;
        logic e;
        @(negedge clk);
        repeat (3) tick();
        chk("R1 out in reset", cell_o, 1'b0);
        rst_n = 1'b1;
        // R1: all table bits and the state read back as zero.
        for (int a = 0; a < 64; a++) begin
            cfg_addr_i = 7'(a);
            #1 chk("R1 table clear", cfg_rdata_o, 1'b0);
        end
        cfg_addr_i = 7'd64;
        #1 chk("R1 state clear", cfg_rdata_o, 1'b0);
        @(negedge clk);

        // R3: program every context, then read back every bit.
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 16; i++) begin
                tbl[c][i] = fgen(c, i);
                cfg_wr(c * 16 + i, tbl[c][i]);
            end
        for (int a = 0; a < 64; a++) begin
            cfg_addr_i = 7'(a);
            #1 chk("R3 readback", cfg_rdata_o, tbl[a / 16][a % 16]);
        end
        @(negedge clk);

        // R2: every input pattern in every context.
        for (int c = 0; c < 4; c++) begin
            select_ctx(c);
            sweep("R2 lookup");
        end

        // R5: the strobe edge applies from the edge after the one that sees it.
        i0 = 0;
        for (int i = 15; i >= 0; i--) if (tbl[3][i] != tbl[1][i]) i0 = i;
        data_i = 4'(i0);
        ctx_idx_i = 2'd1;
        ctx_trig_i = 1'b1;
        tick();
        chk("R5 old ctx at edge", cell_o, tbl[3][i0]);
        ctx_trig_i = 1'b0;
        tick();
        chk("R5 new ctx next edge", cell_o, tbl[1][i0]);
        act = 1;

        // R6: a held or falling strobe ignores index changes.
        ctx_idx_i = 2'd2;
        ctx_trig_i = 1'b1;
        tick();
        act = 2;
        ctx_idx_i = 2'd0;
        sweep("R6 held strobe");
        ctx_idx_i = 2'd3;
        ctx_trig_i = 1'b0;
        tick();
        sweep("R6 falling strobe");

        // R4: a write to an inactive context leaves the output alone.
        tbl[0][5] = ~tbl[0][5];
        cfg_wr(5, tbl[0][5]);
        sweep("R4 inactive write");
        cfg_addr_i = 7'd5;
        #1 chk("R4 readback", cfg_rdata_o, tbl[0][5]);
        @(negedge clk);

        // R7: writing the bit in use takes effect one edge later.
        data_i = 4'd9;
        e = tbl[2][9];
        cfg_we_i = 1'b1;
        cfg_addr_i = 7'(32 + 9);
        cfg_wdata_i = ~e;
        tick();
        chk("R7 old bit", cell_o, e);
        cfg_we_i = 1'b0;
        tbl[2][9] = ~e;
        tick();
        chk("R7 new bit", cell_o, ~e);

        // R9: a state write overrides the lookup and reads back.
        data_i = 4'd3;
        e = ~tbl[2][3];
        cfg_we_i = 1'b1;
        cfg_addr_i = 7'd64;
        cfg_wdata_i = e;
        tick();
        chk("R9 preset", cell_o, e);
        cfg_we_i = 1'b0;
        #1 chk("R9 probe", cfg_rdata_o, e);
        tick();
        chk("R9 lookup resumes", cell_o, tbl[2][3]);
        chk("R9 probe after", cfg_rdata_o, tbl[2][3]);

        // R8: context 3 inverts input 0, which is fed back, so the output toggles.
        for (int i = 0; i < 16; i++) begin
            tbl[3][i] = ~logic'(i & 1);
            cfg_wr(48 + i, tbl[3][i]);
        end
        select_ctx(3);
        data_i = 4'd0;
        fb_sel_i = 4'b0001;
        cfg_wr(64, 1'b0);
        e = 1'b0;
        chk("R8 preset", cell_o, e);
        for (int k = 0; k < 6; k++) begin
            tick();
            e = ~e;
            chk("R8 toggle", cell_o, e);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule